// File: doc/BRIEF.md
# Accumulator-Style 8-Bit Single-Cycle Processor

This block is a small 8-bit processor that completes one instruction on every clock edge. Its instructions live in a 256-word program store of 8-bit words. The top two bits of each word choose one of four kinds of instruction: load a constant, run an ALU operation, move a value between registers, or branch on a condition. Almost every operand is implied by the kind of instruction. Constants always land in R0. The ALU always takes R1 and R2 and writes R3. A branch always jumps to the address held in R0 and tests R3. Only the move instruction names its registers explicitly.

Register addresses 0 to 6 select seven data registers. Address 7 is an I/O port. Reading it samples an input bus, and writing it updates an output register and raises a one-cycle valid strobe. The program store is filled through a write port while the core is held in reset. After reset is released, the core runs from address 0 with every register cleared.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, `pc_o`, `io_out` and `io_out_valid` are 0, and registers R0 to R6 are cleared. After release, execution starts at address 0.
- R2: A clock edge with `prog_we` high and `rst_n` low stores `prog_data` at `prog_addr`. Writes presented while `rst_n` is high are ignored.
- R3: When bits [7:6] of a word are 00, the word loads R0 with its bits [5:0], zero-extended. The value is therefore 0 to 63.
- R4: When bits [7:6] are 01, the word writes R3 from R1 and R2, chosen by bits [5:0]: 0 gives OR, 1 gives NAND, 2 gives NOR, 3 gives AND and 6 gives XOR.
- R5: ALU code 7 gives R1 shifted left by R2, and a shift of 8 or more gives 0. Every ALU code above 7 writes 0 to R3.
- R6: ALU code 4 gives R1+R2 and code 5 gives R1−R2, both taken modulo 256. No carry or flag is kept.
- R7: When bits [7:6] are 10, the word copies the register addressed by bits [5:3] into the register addressed by bits [2:0]. A source address of 7 takes the value on `io_in`.
- R8: A copy whose destination address is 7 loads `io_out` at that edge and drives `io_out_valid` high for exactly the following cycle. `io_out` changes at no other time.
- R9: When bits [7:6] are 11, bits [2:0] choose the condition on R3 read as a signed value: 0 never, 1 equal to 0, 2 less than 0, 3 at most 0, 4 always, 5 not 0, 6 at least 0, 7 greater than 0. Bits [5:3] are ignored.
- R10: A taken branch sets the PC to R0. Every other instruction, including a branch that is not taken, advances the PC by one.
- R11: The PC advances from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables program loading |
| prog_we | input | 1 | Program-store write enable, honoured only in reset |
| prog_addr | input | 8 | Program-store write address |
| prog_data | input | 8 | Program word to store |
| io_in | input | 8 | Value returned when register address 7 is read |
| io_out | output | 8 | Last value written to register address 7 |
| io_out_valid | output | 1 | One-cycle pulse after each write to address 7 |
| pc_o | output | 8 | Address of the instruction now executing |

## Verification
The bench builds the core with its default parameters: 8-bit data and an 8-bit PC. This gives a full 256-word program store, so a straight run of no-operation words reaches the wrap from 255 to 0 within a few hundred cycles. It also makes the store large enough to hold a word that a write during run-time would corrupt.

The bench runs three kinds of program and compares the PC and the I/O outputs against its own model on every cycle:
- a directed program that walks every ALU code and takes several branches;
- a mostly-idle program that wraps the PC while stray writes arrive on the load port;
- fully random programs, with random input data and write attempts.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int INSTR_W  = 8;
  localparam int RADDR_W  = 3;
  localparam int IMM_W    = 6;
  localparam int NADDR    = 1 << RADDR_W;
  localparam int IO_ADDR  = NADDR - 1;

  typedef enum logic [1:0] {
    K_IMM    = 2'b00,
    K_CALC   = 2'b01,
    K_COPY   = 2'b10,
    K_BRANCH = 2'b11
  } kind_e;

  typedef enum logic [IMM_W-1:0] {
    OP_OR   = 6'd0,
    OP_NAND = 6'd1,
    OP_NOR  = 6'd2,
    OP_AND  = 6'd3,
    OP_ADD  = 6'd4,
    OP_SUB  = 6'd5,
    OP_XOR  = 6'd6,
    OP_SHL  = 6'd7
  } aluop_e;
endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [IMM_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_OR:   y = a | b;
      OP_NAND: y = ~(a & b);
      OP_NOR:  y = ~(a | b);
      OP_AND:  y = a & b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/acc8_cond.sv
module acc8_cond #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        cond,
  input  logic [DATA_W-1:0] val,
  output logic              take
);
  logic is_neg;
  logic is_zero;
  logic base;

  assign is_neg  = val[DATA_W-1];
  assign is_zero = (val == '0);

  // Codes 4..7 are the complements of codes 0..3.
  always_comb begin
    case (cond[1:0])
      2'b00:   base = 1'b0;
      2'b01:   base = is_zero;
      2'b10:   base = is_neg;
      default: base = is_neg | is_zero;
    endcase
    take = cond[2] ? ~base : base;
  end
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imm_we,
  input  logic [DATA_W-1:0]  imm_val,
  input  logic               alu_we,
  input  logic [DATA_W-1:0]  alu_val,
  input  logic               cp_we,
  input  logic [RADDR_W-1:0] cp_src,
  input  logic [RADDR_W-1:0] cp_dst,
  input  logic [DATA_W-1:0]  io_in,
  output logic [DATA_W-1:0]  r0,
  output logic [DATA_W-1:0]  r1,
  output logic [DATA_W-1:0]  r2,
  output logic [DATA_W-1:0]  r3,
  output logic [DATA_W-1:0]  io_out,
  output logic               io_out_valid
);
  localparam int NREG = NADDR - 1;

  logic [NADDR-1:0][DATA_W-1:0] rd_src;
  logic [DATA_W-1:0]            cp_val;
  logic                         io_we;
  logic [DATA_W-1:0]            io_d;
  logic [DATA_W-1:0]            io_q;
  logic                         vld_q;

  assign cp_val             = rd_src[cp_src];
  assign rd_src[IO_ADDR]    = io_in;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic              we;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      we = cp_we && (cp_dst == RADDR_W'(gi));
      d  = cp_val;
      if (gi == 0 && imm_we) begin
        we = 1'b1;
        d  = imm_val;
      end
      if (gi == 3 && alu_we) begin
        we = 1'b1;
        d  = alu_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end

    assign rd_src[gi] = q;
  end

  assign r0 = rd_src[0];
  assign r1 = rd_src[1];
  assign r2 = rd_src[2];
  assign r3 = rd_src[3];

  always_comb begin
    io_we = cp_we && (cp_dst == RADDR_W'(IO_ADDR));
    io_d  = io_we ? cp_val : io_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      io_q  <= io_d;
      vld_q <= io_we;
    end
  end

  assign io_out       = io_q;
  assign io_out_valid = vld_q;

  // R3: a constant load never leaves R0 above 63
  p_r0_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imm_we |=> (r0 < DATA_W'(64)));
  // R8: a write to the port is followed by the strobe carrying the moved value
  p_io_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_we |=> (io_out_valid && io_out == $past(cp_val)));
  // R8: without a port write the strobe stays low and the output holds
  p_io_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_we |=> (!io_out_valid && $stable(io_out)));
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic [DATA_W-1:0] io_in,
  output logic [DATA_W-1:0] io_out,
  output logic              io_out_valid,
  output logic [PC_W-1:0]   pc_o
);
  localparam int MEM_DEPTH = 1 << PC_W;

  logic [INSTR_W-1:0] mem_q [MEM_DEPTH];
  logic [PC_W-1:0]    pc_q;
  logic [PC_W-1:0]    pc_d;
  logic [INSTR_W-1:0] instr;
  kind_e              kind;
  logic               take;
  logic [DATA_W-1:0]  r0, r1, r2, r3;
  logic [DATA_W-1:0]  alu_y;
  logic [DATA_W-1:0]  imm_val;
  logic               mem_we;

  // Program store: loaded only while the core is held in reset
  assign mem_we = prog_we && !rst_n;
  always_ff @(posedge clk) begin
    if (mem_we) mem_q[prog_addr] <= prog_data;
  end

  assign instr   = mem_q[pc_q];
  assign kind    = kind_e'(instr[INSTR_W-1 -: 2]);
  assign imm_val = DATA_W'(instr[IMM_W-1:0]);

  acc8_alu #(.DATA_W(DATA_W)) u_alu (
    .op (instr[IMM_W-1:0]),
    .a  (r1),
    .b  (r2),
    .y  (alu_y)
  );

  acc8_cond #(.DATA_W(DATA_W)) u_cond (
    .cond (instr[2:0]),
    .val  (r3),
    .take (take)
  );

  acc8_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk          (clk),
    .rst_n        (rst_n),
    .imm_we       (kind == K_IMM),
    .imm_val      (imm_val),
    .alu_we       (kind == K_CALC),
    .alu_val      (alu_y),
    .cp_we        (kind == K_COPY),
    .cp_src       (instr[5:3]),
    .cp_dst       (instr[2:0]),
    .io_in        (io_in),
    .r0           (r0),
    .r1           (r1),
    .r2           (r2),
    .r3           (r3),
    .io_out       (io_out),
    .io_out_valid (io_out_valid)
  );

  always_comb begin
    if (kind == K_BRANCH && take) pc_d = r0[PC_W-1:0];
    else                          pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R10 / R11: non-branch words step the PC by one, wrapping at the top
  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != K_BRANCH) |=> (pc_o == $past(pc_o) + 1'b1));
  // R10: a taken branch lands on the R0 value
  p_pc_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRANCH && take) |=> (pc_o == $past(r0[PC_W-1:0])));
  // R9: condition code 0 never redirects
  p_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRANCH && instr[2:0] == 3'd0) |=> (pc_o == $past(pc_o) + 1'b1));
  // R9: condition code 4 always redirects
  p_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BRANCH && instr[2:0] == 3'd4) |=> (pc_o == $past(r0[PC_W-1:0])));
endmodule

// File: tb/acc8_core_bench.sv
module acc8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       prog_we;
  logic [7:0] prog_addr;
  logic [7:0] prog_data;
  logic [7:0] io_in;
  logic [7:0] io_out;
  logic       io_out_valid;
  logic [7:0] pc_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  acc8_core u_acc8_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_we      (prog_we),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .io_in        (io_in),
    .io_out       (io_out),
    .io_out_valid (io_out_valid),
    .pc_o         (pc_o)
  );

  // Behavioural reference model
  int    m_mem [256];
  int    m_r   [7];
  int    m_pc  = 0;
  int    m_io  = 0;
  int    m_val = 0;
  string m_tag = "R1";
  bit [7:0] img [256];

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int ins, op, a, b, res, src, dst, v, s, take;
    ins = m_mem[m_pc];
    m_val = 0;
    take = 0;
    case ((ins >> 6) & 3)
      0: begin m_r[0] = ins & 63; m_tag = "R3"; end
      1: begin
        op = ins & 63; a = m_r[1]; b = m_r[2];
        case (op)
          0: res = a | b;
          1: res = ~(a & b);
          2: res = ~(a | b);
          3: res = a & b;
          4: res = a + b;
          5: res = a - b;
          6: res = a ^ b;
          7: res = (b >= 8) ? 0 : (a << b);
          default: res = 0;
        endcase
        m_r[3] = res & 255;
        if (op == 4 || op == 5) m_tag = "R6";
        else if (op >= 7)       m_tag = "R5";
        else                    m_tag = "R4";
      end
      2: begin
        src = (ins >> 3) & 7; dst = ins & 7;
        v = (src == 7) ? int'(io_in) : m_r[src];
        if (dst == 7) begin m_io = v; m_val = 1; end
        else m_r[dst] = v;
        m_tag = "R7";
      end
      default: begin
        s = (m_r[3] >= 128) ? m_r[3] - 256 : m_r[3];
        case (ins & 7)
          0: take = 0;
          1: take = (s == 0);
          2: take = (s < 0);
          3: take = (s <= 0);
          4: take = 1;
          5: take = (s != 0);
          6: take = (s >= 0);
          default: take = (s > 0);
        endcase
        m_tag = take ? "R10" : "R9";
      end
    endcase
    if (take) m_pc = m_r[0];
    else begin
      if (m_pc == 255) m_tag = "R11";
      m_pc = (m_pc + 1) & 255;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      if (prog_we) m_mem[prog_addr] = prog_data;
      foreach (m_r[i]) m_r[i] = 0;
      m_pc = 0; m_io = 0; m_val = 0; m_tag = "R1";
    end else begin
      model_step();
    end
    #5;
    if (!done) begin
      chk(m_tag, pc_o, m_pc, "pc");
      chk(m_tag, io_out, m_io, "io_out");
      chk("R8", io_out_valid, m_val, "io_out_valid");
    end
  end

  // Hold reset, burn the image, release
  task automatic burn();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      prog_we = 1'b1; prog_addr = 8'(i); prog_data = img[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    @(negedge clk);
    chk("R1", pc_o, 0, "pc in reset");
    chk("R1", io_out, 0, "io_out in reset");
    chk("R1", io_out_valid, 0, "valid in reset");
    rst_n = 1'b1;
  endtask

  task automatic run(int cycles, bit stray_writes);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      io_in     = 8'($urandom);
      prog_we   = stray_writes && ($urandom % 3 == 0);
      prog_addr = 8'($urandom % 4);
      prog_data = 8'($urandom);
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 60000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0; io_in = 8'h5A;
    foreach (m_r[i]) m_r[i] = 0;
    foreach (m_mem[i]) m_mem[i] = 0;
    #1;
    chk("R1", pc_o, 0, "pc at start of reset");
    chk("R1", io_out_valid, 0, "valid at start of reset");

    // Directed: ALU codes (R4 R5 R6), copies (R7 R8), branches (R9 R10)
    foreach (img[i]) img[i] = 8'hC0;
    begin
      bit [7:0] d [$] = '{8'h05, 8'h81, 8'h03, 8'h82,
        8'h40, 8'h9F, 8'h41, 8'h9F, 8'h42, 8'h9F, 8'h43, 8'h9F,
        8'h44, 8'h9F, 8'h45, 8'h9F, 8'h46, 8'h9F, 8'h47, 8'h9F,
        8'h48, 8'h9F, 8'hBC, 8'hA7, 8'h8D, 8'hAF,
        8'h28, 8'h45, 8'hC1, 8'hC7};
      foreach (d[i]) img[i] = d[i];
      img[40] = 8'h01; img[41] = 8'h81; img[42] = 8'h3F; img[43] = 8'h82;
      img[44] = 8'h45; img[45] = 8'h9F; img[46] = 8'h00; img[47] = 8'hEA;
    end
    burn();
    run(300, 1'b0);

    // R2 and R11: idle program wraps while stray writes target address 0
    foreach (img[i]) img[i] = 8'hC0;
    img[0] = 8'h09; img[1] = 8'h87;
    burn();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 8'd0; prog_data = 8'h2A;
    end
    @(negedge clk);
    prog_we = 1'b0;
    run(280, 1'b0);
    chk("R2", io_out, 9, "io_out after write attempted in run");

    // Random programs with random input data and stray writes
    for (int k = 0; k < 3; k++) begin
      foreach (img[i]) img[i] = 8'($urandom);
      burn();
      run(3000, 1'b1);
    end

    finish_up();
  end
endmodule